// File: doc/BRIEF.md
# Shoot-Through Insertion Gate Pulse Generator

This block drives the six gates of a three-phase bridge that sits behind an impedance-source network. The bridge can be deliberately short-circuited across a leg to boost the DC link. Every gate carries an ordinary carrier-compared pulse train, limited to that switch's half-cycle of conduction. On top of that train, short shoot-through pulses are OR-ed in, and each switch accepts them only inside its own 120-degree angular window. The shoot-through pulse width follows a duty ratio that is compared against the same triangular carrier, nominally 20 kHz.

A phase accumulator supplies the fundamental angle, with a full turn equal to the full count of its width. The block also receives the triangular carrier, three per-leg modulating references and the duty ratio. It decodes the angle into conduction and shoot-through windows, makes one carrier comparison per leg and one shared shoot-through comparison, merges the results and registers the six gates. The duty ratio is captured only when the carrier sits at its peak value, so a pulse never changes width half-way through.

All inputs are sampled values that are present every cycle. No handshake applies, so every pin is a plain level with no back-pressure.

Top module: `shoot_gate_gen`

## Requirements
- R1: While `rst` is high, and afterwards until one cycle after the first cycle in which `carrier` equals `CAR_PEAK`, all six gates are 0.
- R2: An upper gate (bit 2k for leg k = 0,1,2) carries its normal pulse, defined as leg reference > `carrier`, only inside its conduction window.
- R3: A lower gate (bit 2k+1) carries its normal pulse, defined as leg reference <= `carrier`, only inside its conduction window. Within a leg, the upper and lower normal pulses therefore never overlap.
- R4: The upper conduction window of leg k spans [120k, 120k+180) degrees. The lower window of the same leg is that span shifted by 180 degrees.
- R5: The lower switches accept shoot-through only in these windows: leg 0 [30,150), leg 1 [150,270), leg 2 [270,30) wrapping.
- R6: The upper switches accept shoot-through only in these windows: leg 0 [210,330), leg 1 [330,90) wrapping, leg 2 [90,210).
- R7: The shoot-through pulse is active when the held duty ratio > `carrier`. It is ANDed with the switch's window and OR-ed with its normal pulse.
- R8: The duty ratio is captured only in a cycle with `carrier` == `CAR_PEAK`. Changes to `st_duty` in any other cycle have no effect on the gates.
- R9: The gates are registered. Their value after a clock edge depends only on inputs present before that edge, and they do not change between edges.
- R10: An angle boundary of D degrees lies at count floor(D * 2^PW / 360). A window whose end is numerically below its start wraps through 360.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | PW | Fundamental angle, full turn = 2^PW |
| carrier | input | DW | Triangular carrier sample, peak `CAR_PEAK` |
| ref_a | input | DW | Modulating reference, leg 0 |
| ref_b | input | DW | Modulating reference, leg 1 |
| ref_c | input | DW | Modulating reference, leg 2 |
| st_duty | input | DW | Shoot-through duty ratio |
| gate | output | 6 | Gate drives: bit 2k upper, bit 2k+1 lower of leg k |

## Verification
A wrong window boundary or wrap shows up at exactly the phase count where the boundary should fall. At that count a gate either keeps its pulse one count too long or loses it one count too early, and the error is visible one clock later. A duty register that loads at the wrong moment shows up at the first non-peak cycle in which `st_duty` differs from the held value and the carrier sits between the two. The shoot-through bits in their windows then disagree in the following cycle. A swapped compare polarity or a missing OR term corrupts a gate in the first cycle in which that term alone decides the output, and a full phase sweep reaches every such cycle.

// File: rtl/sgg_pkg.sv
package sgg_pkg;
  localparam int NUM_LEGS = 3;
  localparam int LEG_DEG  = 120;
  localparam int HALF_DEG = 180;
  localparam int ST_LEN   = 120;
  localparam int UP_ST0   = 210;
  localparam int LO_ST0   = 30;

  // Boundary count for an angle in degrees on a 2^pw circle.
  function automatic longint unsigned deg_cnt(input int deg, input int pw);
    longint unsigned full;
    full = 64'd1 << pw;
    return (longint'(deg % 360) * full) / 64'd360;
  endfunction
endpackage

// File: rtl/sgg_window.sv
module sgg_window #(
  parameter int PW        = 12,
  parameter int START_DEG = 0,
  parameter int LEN_DEG   = 180
) (
  input  logic [PW-1:0] phase,
  output logic          hit
);
  localparam int S_DEG = START_DEG % 360;
  localparam int E_DEG = (START_DEG + LEN_DEG) % 360;
  localparam logic [PW-1:0] S_C = PW'(sgg_pkg::deg_cnt(S_DEG, PW));
  localparam logic [PW-1:0] E_C = PW'(sgg_pkg::deg_cnt(E_DEG, PW));

  logic ge_s, lt_e;

  if (S_DEG == 0) begin : g_s0
    assign ge_s = 1'b1;
  end else begin : g_s
    assign ge_s = (phase >= S_C);
  end

  if (E_DEG == 0) begin : g_e0
    assign lt_e = 1'b0;
  end else begin : g_e
    assign lt_e = (phase < E_C);
  end

  if (S_DEG < E_DEG) begin : g_plain
    assign hit = ge_s & lt_e;
  end else begin : g_wrap
    assign hit = ge_s | lt_e;
  end
endmodule

// File: rtl/sgg_leg.sv
module sgg_leg #(
  parameter int PW  = 12,
  parameter int DW  = 10,
  parameter int LEG = 0
) (
  input  logic [PW-1:0] phase,
  input  logic [DW-1:0] carrier,
  input  logic [DW-1:0] ref_v,
  input  logic          st_hit,
  output logic          up,
  output logic          lo
);
  import sgg_pkg::*;
  localparam int OFS = LEG * LEG_DEG;

  logic up_cond, lo_cond, up_stw, lo_stw;

  sgg_window #(.PW(PW), .START_DEG(OFS),            .LEN_DEG(HALF_DEG)) u_up_cond
    (.phase(phase), .hit(up_cond));
  sgg_window #(.PW(PW), .START_DEG(OFS + HALF_DEG), .LEN_DEG(HALF_DEG)) u_lo_cond
    (.phase(phase), .hit(lo_cond));
  sgg_window #(.PW(PW), .START_DEG(OFS + UP_ST0),   .LEN_DEG(ST_LEN))   u_up_st
    (.phase(phase), .hit(up_stw));
  sgg_window #(.PW(PW), .START_DEG(OFS + LO_ST0),   .LEN_DEG(ST_LEN))   u_lo_st
    (.phase(phase), .hit(lo_stw));

  logic above;
  assign above = (ref_v > carrier);

  assign up = (up_cond & above)  | (up_stw & st_hit);
  assign lo = (lo_cond & ~above) | (lo_stw & st_hit);
endmodule

// File: rtl/sgg_duty_hold.sv
module sgg_duty_hold #(
  parameter int DW       = 10,
  parameter int CAR_PEAK = 1023
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] carrier,
  input  logic [DW-1:0] st_duty,
  output logic [DW-1:0] duty_q,
  output logic          armed
);
  localparam logic [DW-1:0] PEAK = DW'(CAR_PEAK);

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
      armed  <= 1'b0;
    end else if (carrier == PEAK) begin
      duty_q <= st_duty;
      armed  <= 1'b1;
    end
  end
endmodule

// File: rtl/shoot_gate_gen.sv
module shoot_gate_gen #(
  parameter int PW       = 12,
  parameter int DW       = 10,
  parameter int CAR_PEAK = 1023
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] phase,
  input  logic [DW-1:0] carrier,
  input  logic [DW-1:0] ref_a,
  input  logic [DW-1:0] ref_b,
  input  logic [DW-1:0] ref_c,
  input  logic [DW-1:0] st_duty,
  output logic [5:0]    gate
);
  import sgg_pkg::*;
  localparam int NG = 2 * NUM_LEGS;

  logic [DW-1:0] duty_q;
  logic          armed;
  logic          st_hit;
  logic [DW-1:0] refs [NUM_LEGS];
  logic [NG-1:0] gate_raw;

  sgg_duty_hold #(.DW(DW), .CAR_PEAK(CAR_PEAK)) u_hold (
    .clk(clk), .rst(rst), .carrier(carrier), .st_duty(st_duty),
    .duty_q(duty_q), .armed(armed)
  );

  assign st_hit  = (duty_q > carrier);
  assign refs[0] = ref_a;
  assign refs[1] = ref_b;
  assign refs[2] = ref_c;

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    sgg_leg #(.PW(PW), .DW(DW), .LEG(k)) u_leg (
      .phase(phase), .carrier(carrier), .ref_v(refs[k]), .st_hit(st_hit),
      .up(gate_raw[2*k]), .lo(gate_raw[2*k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !armed) gate <= '0;
    else               gate <= gate_raw;
  end
endmodule

// File: rtl/sgg_checker.sv
module sgg_checker #(
  parameter int PW       = 12,
  parameter int DW       = 10,
  parameter int CAR_PEAK = 1023
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] phase,
  input logic [DW-1:0] carrier,
  input logic [DW-1:0] ref_a,
  input logic [DW-1:0] ref_b,
  input logic [DW-1:0] ref_c,
  input logic [DW-1:0] st_duty,
  input logic [5:0]    gate,
  input logic [DW-1:0] duty_q,
  input logic          armed
);
  localparam logic [DW-1:0] PEAK = DW'(CAR_PEAK);

  // R1: reset clears all gates
  a_r1_reset_low: assert property (@(posedge clk) rst |=> gate == 6'b0);

  // R1: no gate before the first carrier peak has been seen
  a_r1_unarmed_low: assert property (@(posedge clk) disable iff (rst)
    !armed |=> gate == 6'b0);

  // R8: held duty moves only on a peak cycle
  a_r8_duty_hold: assert property (@(posedge clk) disable iff (rst)
    (carrier != PEAK) |=> $stable(duty_q));

  // R8: a peak cycle loads the presented duty
  a_r8_duty_load: assert property (@(posedge clk) disable iff (rst)
    (carrier == PEAK) |=> duty_q == $past(st_duty));

  // R3: with zero duty no leg has both switches on
  a_r3_zero_duty_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (duty_q == '0) |=> !(gate[0] & gate[1]) && !(gate[2] & gate[3]) && !(gate[4] & gate[5]));

  // R9: unchanged inputs and state give unchanged gates
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(phase) && $stable(carrier) && $stable(ref_a) &&
     $stable(ref_b) && $stable(ref_c) && $stable(duty_q) && $stable(armed))
    |=> $stable(gate));
endmodule

bind shoot_gate_gen sgg_checker #(.PW(PW), .DW(DW), .CAR_PEAK(CAR_PEAK)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .carrier(carrier), .ref_a(ref_a),
  .ref_b(ref_b), .ref_c(ref_c), .st_duty(st_duty), .gate(gate),
  .duty_q(duty_q), .armed(armed)
);

// File: tb/shoot_gate_gen_bench.sv
module shoot_gate_gen_bench;
  localparam int PW   = 12;
  localparam int DW   = 10;
  localparam int PEAK = 1023;
  localparam longint FULL = 64'd1 << PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] phase = '0;
  logic [DW-1:0] carrier = '0, ref_a = '0, ref_b = '0, ref_c = '0, st_duty = '0;
  logic [5:0] gate;

  int n_chk = 0, n_bad = 0;
  int m_duty = 0;
  bit m_armed = 0;
  logic [5:0] prev_exp = '0;
  bit done = 0;

  always #5 clk = ~clk;

  shoot_gate_gen #(.PW(PW), .DW(DW), .CAR_PEAK(PEAK)) u_shoot_gate_gen (
    .clk(clk), .rst(rst), .phase(phase), .carrier(carrier), .ref_a(ref_a),
    .ref_b(ref_b), .ref_c(ref_c), .st_duty(st_duty), .gate(gate)
  );

  // R10: boundary D sits at floor(D*FULL/360); p reached it when (p+1)*360 > D*FULL
  function automatic bit past_b(int p, int d);
    return (longint'(p + 1) * 360) > (longint'(d) * FULL);
  endfunction

  function automatic bit in_win(int p, int sdeg, int ldeg);
    int s, e;
    s = sdeg % 360;
    e = (sdeg + ldeg) % 360;
    if (s < e) return past_b(p, s) && !past_b(p, e);
    return past_b(p, s) || !past_b(p, e);
  endfunction

  function automatic logic [5:0] model(int p, int car, int ra, int rb, int rc, int duty);
    logic [5:0] g;
    int r;
    bit st;
    st = duty > car;
    for (int k = 0; k < 3; k++) begin
      r = (k == 0) ? ra : (k == 1) ? rb : rc;
      // R2 R4 R6 R7
      g[2*k]   = (in_win(p, 120*k, 180) && (r > car)) || (in_win(p, 210 + 120*k, 120) && st);
      // R3 R4 R5 R7
      g[2*k+1] = (in_win(p, 180 + 120*k, 180) && (r <= car)) || (in_win(p, 30 + 120*k, 120) && st);
    end
    return g;
  endfunction

  task automatic cmp(logic [5:0] act, logic [5:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s phase=%0d carrier=%0d gate=%b expected=%b", tag, phase, carrier, act, exp);
    end
  endtask

  task automatic cyc(bit r, int p, int car, int ra, int rb, int rc, int dut, string tag);
    logic [5:0] exp;
    @(negedge clk);
    rst = r; phase = PW'(p); carrier = DW'(car);
    ref_a = DW'(ra); ref_b = DW'(rb); ref_c = DW'(rc); st_duty = DW'(dut);
    if (r) begin
      exp = '0; m_armed = 0; m_duty = 0;
    end else begin
      exp = m_armed ? model(p, car, ra, rb, rc, m_duty) : 6'b0;
      if (car == PEAK) begin m_duty = dut; m_armed = 1; end
    end
    #4;
    cmp(gate, prev_exp, "R9 before edge");
    @(posedge clk); #1;
    cmp(gate, exp, tag);
    prev_exp = exp;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset and pre-peak quiet period
    for (int i = 0; i < 3; i++) cyc(1, 100, 10, 900, 900, 900, 800, "R1 reset");
    for (int i = 0; i < 4; i++) cyc(0, 100 + i, 10, 900, 900, 900, 800, "R1 before peak");
    cyc(0, 100, PEAK, 900, 900, 900, 800, "R1 peak cycle");
    cyc(0, 100, 10, 900, 900, 900, 0, "R1 R7 first armed");

    // R8: non-peak duty changes ignored (phase 90 deg: lower leg0 window open)
    for (int i = 0; i < 6; i++)
      cyc(0, 1024, 400 + i * 50, 0, 0, 0, (i % 2) ? 1023 : 0, "R8 duty ignored");
    cyc(0, 1024, PEAK, 0, 0, 0, 0, "R8 reload");
    cyc(0, 1024, 0, 0, 0, 0, 1023, "R8 zero duty held");

    // R2-R7, R10: full phase sweeps with varied carrier, refs and duties
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < (1 << PW); p++) begin
        int car, dn;
        if (p % 512 == 0) begin
          dn = ((p / 512) * 173 + pass * 389) % 1024;
          if (p == 0 && pass == 1) dn = 1023;
          cyc(0, p, PEAK, 300, 600, 900, dn, "R2 R3 R5 R6 R7 R10 sweep peak");
        end
        car = (p * 97 + pass * 311) % 1023;
        cyc(0, p, car, (p * 13) % 1024, (p * 29 + 500) % 1024, 1023 - (p % 1024),
            (p * 7) % 1024, "R2 R3 R4 R5 R6 R7 R10 sweep");
      end
    end

    // R1: reset mid-run clears the gates again
    cyc(1, 2000, 5, 1000, 1000, 1000, 900, "R1 reset again");
    cyc(0, 2000, 5, 1000, 1000, 1000, 900, "R1 unarmed after reset");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule